// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory, one 32-bit word at a time. A walk starts at an entry in a context table, found from a context table pointer and a context number, and then descends through up to three directory levels indexed by virtual address fields of 8, 6 and 6 bits. A leaf entry may be found at any of those three levels, mapping a 16 MB, 256 KB or 4 KB page. When the walk succeeds, the walker updates the leaf's accessed flag (and, for a write access, its modified flag) in memory with a single write, issued only if a flag actually changes.

The surrounding logic pulses a request with the address, access kind, context pointer and context number. The walker raises `busy` for the length of the walk, keeps at most one memory access outstanding, and finishes with a one-cycle `done` pulse with the physical address, page size code, leaf permission field and fault code.

The controller has five states. IDLE waits for a request (IDLE to FETCH on `req_valid`). FETCH holds a read until it is acknowledged (FETCH to EVAL). EVAL classifies the fetched word: a directory pointer above the deepest level goes back to FETCH one level down; a leaf needing a flag update goes to WBACK; a leaf needing none, or any fault, goes to FINISH. WBACK holds the write until it is acknowledged (WBACK to FINISH). FINISH raises `done` for one cycle and returns to IDLE.

Top module: `tbl_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low and `res_fault` is zero.
- R2: The first read of a walk is at address (context pointer << 4) + (context number << 2).
- R3: Every read and write is word aligned; a directory read goes to ((entry bits [31:2]) << 6) + 4 × index, with index = VA[31:24], VA[23:18], VA[17:12] at levels 1, 2, 3.
- R4: A leaf at level 1 gives size code 2 (16 MB) and physical address (leaf[31:8] << 12) + VA[23:0].
- R5: A leaf at level 2 gives size code 1 (256 KB) and physical address (leaf[31:8] << 12) + VA[17:0].
- R6: A leaf at level 3 gives size code 0 (4 KB) and physical address (leaf[31:8] << 12) + VA[11:0].
- R7: An entry whose bits [1:0] are 0 ends the walk with fault code bits [9:8] = level (0 to 3) and bits [4:2] = 1, all other bits zero.
- R8: A reserved entry (type 3), a read error, a leaf (type 2) at the context level, or a directory (type 1) at level 3 ends the walk with bits [9:8] = level and bits [4:2] = 4.
- R9: After a successful walk the leaf is rewritten at its own address with bit 5 (accessed) set, and on a write access also bit 6 (modified) set.
- R10: When those flags already hold, no write is issued.
- R11: `busy` is high from the cycle after the request until `done`; `done` lasts one cycle with `busy` low; a pending access keeps its address until acknowledged.
- R12: A request while busy is ignored, and the request inputs may change once the request is taken without affecting the walk.
- R13: A successful walk reports the leaf bits [4:2] as the permission field and fault code zero; a faulted walk reports address, size and permission as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_write | input | 1 | Access is a write |
| req_vaddr | input | 32 | Virtual address |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| res_paddr | output | PA_W | Physical address |
| res_size | output | 2 | Page size code: 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| res_perm | output | 3 | Leaf permission field |
| res_fault | output | 10 | Fault code: [9:8] level, [4:2] type |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | PA_W | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Read error, valid with `mem_ack` |

## Verification
Walks are run that end in a leaf at each of the three levels, so the size code and the span of virtual bits carried into the physical address are told apart per level. The same 4 KB page is walked as a read and a write with its flags clear, partly set and fully set, which separates a needed write-back from a skipped one and the accessed update from the modified one. Faults are placed at every level with invalid, reserved, error and wrong-type entries, so level and type encoding are checked independently, and a second context pointer and number check the first-read address. A request pulsed mid-walk with the inputs scrambled shows that the walk in progress is not disturbed.

// File: rtl/tbl_walker_pkg.sv
package tbl_walker_pkg;

    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int CTP_W  = 32;
    localparam int PG_SH  = 12;
    localparam int CTP_SH = 4;
    localparam int ENT_SH = 2;
    localparam int LVL_W  = 2;
    localparam int FC_W   = 10;

    localparam int IDX_W1 = 8;
    localparam int IDX_W2 = 6;
    localparam int IDX_W3 = 6;
    localparam int NUM_DIR_LVLS = 3;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_DIR_LVLS);

    localparam int ACC_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam int PERM_LO = 2;
    localparam int PERM_HI = 4;
    localparam int PPN_LO  = 8;

    function automatic int lvl_idx_w(input int lvl);
        return (lvl == 1) ? IDX_W1 : ((lvl == 2) ? IDX_W2 : IDX_W3);
    endfunction

    function automatic int lvl_idx_lo(input int lvl);
        return (lvl == 1) ? (PG_SH + IDX_W3 + IDX_W2)
             : ((lvl == 2) ? (PG_SH + IDX_W3) : PG_SH);
    endfunction

    function automatic int lvl_idx_hi(input int lvl);
        return lvl_idx_lo(lvl) + lvl_idx_w(lvl) - 1;
    endfunction

    localparam int OFF1_W = lvl_idx_lo(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_WBACK,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_DIR     = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [2:0] {
        FT_NONE    = 3'd0,
        FT_INVALID = 3'd1,
        FT_XLATE   = 3'd4
    } ftype_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_LEAF,
        ACT_FAULT
    } act_e;

    typedef enum logic [1:0] {
        SZ_4K   = 2'd0,
        SZ_256K = 2'd1,
        SZ_16M  = 2'd2
    } pgsz_e;

endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import tbl_walker_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input  logic [LVL_W-1:0]    level,
    input  logic [CTP_W-1:0]    ctx_ptr,
    input  logic [CTX_W-1:0]    ctx_num,
    input  logic [VA_W-1:PG_SH] vpn,
    input  logic [ENT_W-1:2]    dir_ptr,
    output logic [PA_W-1:0]     addr
);

    logic [PA_W-1:0] ctx_addr;
    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] idx_off [1:NUM_DIR_LVLS];

    // context table slot: pointer scaled to a byte address, plus word index
    assign ctx_addr = (PA_W'(ctx_ptr) << CTP_SH) + (PA_W'(ctx_num) << ENT_SH);

    // next table base taken from the directory entry's pointer field
    assign tbl_base = PA_W'({dir_ptr, 2'b00}) << CTP_SH;

    for (genvar g = 1; g <= NUM_DIR_LVLS; g++) begin : g_idx
        localparam int HI = lvl_idx_hi(g);
        localparam int LO = lvl_idx_lo(g);
        assign idx_off[g] = PA_W'(vpn[HI:LO]) << ENT_SH;
    end

    always_comb begin
        unique case (level)
            2'd1:    addr = tbl_base + idx_off[1];
            2'd2:    addr = tbl_base + idx_off[2];
            2'd3:    addr = tbl_base + idx_off[3];
            default: addr = ctx_addr;
        endcase
    end

endmodule

// File: rtl/walk_entry_classify.sv
module walk_entry_classify
    import tbl_walker_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       etype,
    input  logic             bus_err,
    output act_e             act,
    output logic [FC_W-1:0]  fault_code
);

    ftype_e ft;

    always_comb begin
        act = ACT_FAULT;
        ft  = FT_XLATE;
        if (!bus_err) begin
            unique case (ent_type_e'(etype))
                ET_INVALID: ft = FT_INVALID;
                ET_DIR: begin
                    if (level != LAST_LVL) begin
                        act = ACT_DESCEND;
                        ft  = FT_NONE;
                    end
                end
                ET_LEAF: begin
                    if (level != '0) begin
                        act = ACT_LEAF;
                        ft  = FT_NONE;
                    end
                end
                ET_RSVD: ft = FT_XLATE;
                default: ft = FT_XLATE;
            endcase
        end
        fault_code = (act == ACT_FAULT) ? {level, 3'b000, ft, 2'b00} : '0;
    end

endmodule

// File: rtl/walk_leaf_compose.sv
module walk_leaf_compose
    import tbl_walker_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [ENT_W-1:0]  leaf,
    input  logic [OFF1_W-1:0] voff,
    input  logic              is_write,
    output logic [PA_W-1:0]   paddr,
    output pgsz_e             size,
    output logic [2:0]        perm,
    output logic [ENT_W-1:0]  wb_data,
    output logic              wb_needed
);

    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] offs [1:NUM_DIR_LVLS];
    logic [PA_W-1:0] off_sel;

    assign frame = PA_W'(leaf[ENT_W-1:PPN_LO]) << PG_SH;

    // a leaf at level n keeps every virtual bit below that level's index
    for (genvar g = 1; g <= NUM_DIR_LVLS; g++) begin : g_off
        localparam int TOP = lvl_idx_lo(g) - 1;
        assign offs[g] = PA_W'(voff[TOP:0]);
    end

    always_comb begin
        unique case (level)
            2'd1: begin
                off_sel = offs[1];
                size    = SZ_16M;
            end
            2'd2: begin
                off_sel = offs[2];
                size    = SZ_256K;
            end
            2'd3: begin
                off_sel = offs[3];
                size    = SZ_4K;
            end
            default: begin
                off_sel = '0;
                size    = SZ_4K;
            end
        endcase
    end

    assign paddr = frame + off_sel;
    assign perm  = leaf[PERM_HI:PERM_LO];

    always_comb begin
        wb_data = leaf;
        wb_data[ACC_BIT] = 1'b1;
        if (is_write) begin
            wb_data[MOD_BIT] = 1'b1;
        end
        wb_needed = (wb_data != leaf);
    end

endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
    import tbl_walker_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_vaddr,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              busy,
    output logic              done,
    output logic [PA_W-1:0]   res_paddr,
    output logic [1:0]        res_size,
    output logic [2:0]        res_perm,
    output logic [9:0]        res_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);

    walk_state_e state_q, state_d;

    logic [LVL_W-1:0] level_q;
    logic [VA_W-1:0]  vaddr_q;
    logic             write_q;
    logic [CTP_W-1:0] ctxp_q;
    logic [CTX_W-1:0] ctxn_q;
    logic [ENT_W-1:0] entry_q;
    logic             err_q;
    logic [PA_W-1:0]  ent_addr_q;

    logic [PA_W-1:0]  gen_addr;
    act_e             act;
    logic [FC_W-1:0]  fault_code;
    logic [PA_W-1:0]  leaf_paddr;
    pgsz_e            leaf_size;
    logic [2:0]       leaf_perm;
    logic [ENT_W-1:0] wb_data;
    logic             wb_needed;

    walk_addr_gen #(
        .CTX_W (CTX_W),
        .PA_W  (PA_W)
    ) u_addr (
        .level   (level_q),
        .ctx_ptr (ctxp_q),
        .ctx_num (ctxn_q),
        .vpn     (vaddr_q[VA_W-1:PG_SH]),
        .dir_ptr (entry_q[ENT_W-1:2]),
        .addr    (gen_addr)
    );

    walk_entry_classify u_class (
        .level      (level_q),
        .etype      (entry_q[1:0]),
        .bus_err    (err_q),
        .act        (act),
        .fault_code (fault_code)
    );

    walk_leaf_compose #(
        .PA_W (PA_W)
    ) u_leaf (
        .level     (level_q),
        .leaf      (entry_q),
        .voff      (vaddr_q[OFF1_W-1:0]),
        .is_write  (write_q),
        .paddr     (leaf_paddr),
        .size      (leaf_size),
        .perm      (leaf_perm),
        .wb_data   (wb_data),
        .wb_needed (wb_needed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_ack) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                unique case (act)
                    ACT_DESCEND: state_d = ST_FETCH;
                    ACT_LEAF:    state_d = wb_needed ? ST_WBACK : ST_FINISH;
                    default:     state_d = ST_FINISH;
                endcase
            end
            ST_WBACK: begin
                if (mem_ack) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // walk context: request capture, fetched entry, level counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= '0;
            vaddr_q    <= '0;
            write_q    <= 1'b0;
            ctxp_q     <= '0;
            ctxn_q     <= '0;
            entry_q    <= '0;
            err_q      <= 1'b0;
            ent_addr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        level_q <= '0;
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        ctxp_q  <= ctx_ptr;
                        ctxn_q  <= ctx_num;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        entry_q    <= mem_rdata;
                        err_q      <= mem_err;
                        ent_addr_q <= gen_addr;
                    end
                end
                ST_EVAL: begin
                    if (act == ACT_DESCEND) begin
                        level_q <= level_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_paddr <= '0;
            res_size  <= '0;
            res_perm  <= '0;
            res_fault <= '0;
        end else if (state_q == ST_EVAL) begin
            if (act == ACT_LEAF) begin
                res_paddr <= leaf_paddr;
                res_size  <= leaf_size;
                res_perm  <= leaf_perm;
                res_fault <= '0;
            end else if (act == ACT_FAULT) begin
                res_paddr <= '0;
                res_size  <= '0;
                res_perm  <= '0;
                res_fault <= fault_code;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = gen_addr;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: begin
                busy    = 1'b1;
                mem_req = 1'b1;
            end
            ST_EVAL: busy = 1'b1;
            ST_WBACK: begin
                busy      = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr_q;
                mem_wdata = wb_data;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r9_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[ACC_BIT] && (mem_wdata[MOD_BIT] || !write_q)));

    a_r13_fault_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (res_fault != '0)) |-> ((res_paddr == '0) && (res_perm == '0)));

    a_r12_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/tbl_walker_test.sv
`timescale 1ns/1ps
module tbl_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] ctx_ptr = '0;
    logic [7:0]  ctx_num = '0;
    logic        busy, done;
    logic [35:0] res_paddr;
    logic [1:0]  res_size;
    logic [2:0]  res_perm;
    logic [9:0]  res_fault;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    always #2.5 clk = ~clk;

    tbl_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
        .busy(busy), .done(done),
        .res_paddr(res_paddr), .res_size(res_size), .res_perm(res_perm), .res_fault(res_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    typedef struct packed {
        logic [35:0] paddr;
        logic [1:0]  size;
        logic [2:0]  perm;
        logic [9:0]  fault;
        bit          wb;
        logic [35:0] wb_addr;
        logic [31:0] wb_val;
        int          wr_before;
    } exp_t;

    exp_t  sb[$];
    string tagq[$];
    int    checks = 0;
    int    fails = 0;
    int    wr_count = 0;
    int    resp_n = 0;
    int    wait_left = 0;
    logic [31:0] mem [logic [35:0]];
    bit          err_at [logic [35:0]];

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mkdir(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] mkleaf(input logic [23:0] ppn, input logic [2:0] perm,
                                           input bit m, input bit a);
        return {ppn, 1'b0, m, a, perm, 2'b10};
    endfunction

    // expected result computed from the requirements on the bench's memory image
    function automatic exp_t ref_walk(input logic [31:0] va, input bit wr,
                                      input logic [31:0] ptr, input logic [7:0] ctx);
        exp_t        e;
        logic [35:0] a;
        logic [31:0] ent;
        logic [31:0] nv;
        logic [35:0] off;
        int          lvl;
        bit          fin;
        e   = '0;
        a   = {ptr, 4'h0} + {26'h0, ctx, 2'b00};
        lvl = 0;
        fin = 0;
        while (!fin) begin
            ent = rd(a);
            if (err_at.exists(a) || ent[1:0] == 2'd3 ||
                (ent[1:0] == 2'd2 && lvl == 0) || (ent[1:0] == 2'd1 && lvl == 3)) begin
                e.fault = {2'(lvl), 3'b000, 3'd4, 2'b00};
                fin = 1;
            end else if (ent[1:0] == 2'd0) begin
                e.fault = {2'(lvl), 3'b000, 3'd1, 2'b00};
                fin = 1;
            end else if (ent[1:0] == 2'd1) begin
                lvl++;
                if (lvl == 1)      a = {ent[31:2], 6'b0} + {26'h0, va[31:24], 2'b00};
                else if (lvl == 2) a = {ent[31:2], 6'b0} + {28'h0, va[23:18], 2'b00};
                else               a = {ent[31:2], 6'b0} + {28'h0, va[17:12], 2'b00};
            end else begin
                if (lvl == 1) begin
                    off = {12'h0, va[23:0]};
                    e.size = 2'd2;
                end else if (lvl == 2) begin
                    off = {18'h0, va[17:0]};
                    e.size = 2'd1;
                end else begin
                    off = {24'h0, va[11:0]};
                    e.size = 2'd0;
                end
                e.paddr = {ent[31:8], 12'h0} + off;
                e.perm  = ent[4:2];
                nv = ent | 32'h20 | (wr ? 32'h40 : 32'h0);
                e.wb      = (nv != ent);
                e.wb_addr = a;
                e.wb_val  = nv;
                fin = 1;
            end
        end
        return e;
    endfunction

    // memory responder: variable latency, writes update the image
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                if (wait_left > 0) begin
                    wait_left--;
                end else begin
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_count++;
                    end else begin
                        mem_rdata = rd(mem_addr);
                        mem_err   = err_at.exists(mem_addr);
                    end
                    mem_ack = 1'b1;
                    resp_n++;
                    wait_left = resp_n % 3;
                end
            end
        end
    end

    // monitor: pops the scoreboard on each result strobe
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check("R12", "unexpected done", 64'd1, 64'd0);
                end else begin
                    e = sb.pop_front();
                    t = tagq.pop_front();
                    check("R11", "busy during done", busy, 0);
                    check(t, "paddr", res_paddr, e.paddr);
                    check(t, "size", res_size, e.size);
                    check(t, "perm R13", res_perm, e.perm);
                    check(t, "fault", res_fault, e.fault);
                    check(e.wb ? "R9" : "R10", "write count", wr_count - e.wr_before, e.wb ? 1 : 0);
                    if (e.wb) begin
                        check("R9", "leaf after write-back", rd(e.wb_addr), e.wb_val);
                    end
                end
            end
        end
    end

    task automatic run_walk(input string tag, input logic [31:0] va, input bit wr,
                            input logic [31:0] ptr, input logic [7:0] ctx, input bit poke);
        exp_t e;
        @(negedge clk);
        e = ref_walk(va, wr, ptr, ctx);
        e.wr_before = wr_count;
        sb.push_back(e);
        tagq.push_back(tag);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        ctx_ptr   = ptr;
        ctx_num   = ctx;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'hFFFF_FFFF;
        req_write = ~wr;
        ctx_ptr   = 32'h0;
        ctx_num   = 8'hFF;
        check("R11", "busy after request", busy, 1);
        check("R2", "first access pending", mem_req, 1);
        check("R2", "first read address", mem_addr, {ptr, 4'h0} + {26'h0, ctx, 2'b00});
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = 32'h0900_0000;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check("R11", "watchdog expired", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        mem[36'h1000C]              = mkdir(36'h20000);
        mem[36'h20000 + 36'h05 * 4] = mkdir(36'h30000);
        mem[36'h30000 + 36'h12 * 4] = mkdir(36'h40000);
        mem[36'h40000 + 36'h0D * 4] = mkleaf(24'hABCDE1, 3'd3, 1'b0, 1'b0);
        mem[36'h30000 + 36'h31 * 4] = mkleaf(24'h123400, 3'd5, 1'b0, 1'b0);
        mem[36'h20000 + 36'h7A * 4] = mkleaf(24'h800000, 3'd6, 1'b1, 1'b1);
        mem[36'h30000 + 36'h02 * 4] = 32'h0000_0003;
        err_at[36'h40000 + 36'h02 * 4] = 1'b1;
        mem[36'h40000 + 36'h03 * 4] = mkdir(36'h50000);
        mem[36'h10000 + 36'h06 * 4] = mkleaf(24'h000001, 3'd7, 1'b0, 1'b0);
        err_at[36'h10000 + 36'h07 * 4] = 1'b1;
        mem[36'h20000 + 36'h0A * 4] = 32'h0000_0003;
        mem[36'h60004]              = mkdir(36'h20000);

        repeat (4) @(negedge clk);
        check("R1", "busy in reset", busy, 0);
        check("R1", "done in reset", done, 0);
        check("R1", "mem_req in reset", mem_req, 0);
        check("R1", "fault in reset", res_fault, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "idle after reset", busy, 0);

        run_walk("R6 R3 read flags clear",  32'h0548_D7A4, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R10 read accessed set",   32'h0548_D000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R9 write modified clear", 32'h0548_D010, 1'b1, 32'h1000, 8'd3, 1'b0);
        run_walk("R10 write flags set",     32'h0548_D000, 1'b1, 32'h1000, 8'd3, 1'b0);
        run_walk("R5 R9 level-2 leaf",      32'h05C7_3ABC, 1'b1, 32'h1000, 8'd3, 1'b0);
        run_walk("R4 R13 level-1 leaf",     32'h7A5B_6123, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R7 invalid at level 1",   32'h0900_0000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R7 invalid at level 2",   32'h0504_0000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R7 invalid at level 3",   32'h0548_1000, 1'b1, 32'h1000, 8'd3, 1'b0);
        run_walk("R7 invalid at context",   32'h0548_D000, 1'b0, 32'h1000, 8'd5, 1'b0);
        run_walk("R8 reserved at level 2",  32'h0508_0000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R8 read error level 3",   32'h0548_2000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R8 directory at level 3", 32'h0548_3000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R8 leaf at context",      32'h0000_0000, 1'b0, 32'h1000, 8'd6, 1'b0);
        run_walk("R8 read error context",   32'h0000_0000, 1'b0, 32'h1000, 8'd7, 1'b0);
        run_walk("R8 reserved at level 1",  32'h0A00_0000, 1'b0, 32'h1000, 8'd3, 1'b0);
        run_walk("R2 second context table", 32'h7A00_0040, 1'b0, 32'h6000, 8'd1, 1'b0);
        run_walk("R12 request while busy",  32'h0548_D000, 1'b0, 32'h1000, 8'd3, 1'b1);

        repeat (10) @(negedge clk);
        check("R12", "no pending result", sb.size(), 0);
        check("R12", "idle at end", busy, 0);
        finish_run();
    end

endmodule